// File: doc/BRIEF.md
# Serial Port Register File with Modem Loopback

This block is the register file that a processor sees on a classic eight-offset asynchronous serial port. A 3-bit offset with separate read and write strobes selects the registers. Writes set the line format, the modem control lines, the interrupt enables and a 16-bit baud divisor. Reads return received data, line status, modem status and an interrupt identification byte. Read data is registered and appears on the clock after the read strobe.

The serial shift engine is a separate block and connects through plain ports. It supplies the received byte, the data-ready flag, the four line error flags and the two transmitter-empty flags. It receives the transmit byte with a load strobe, a take strobe when the receive buffer is read, and a strobe when line status is read. The line format and divisor are presented as decoded outputs.

The block has a diagnostic loop mode. In this mode the modem control outputs feed the modem status inputs internally, so software can exercise every status and change flag without a cable. Change flags on the modem lines and the other conditions feed a prioritised interrupt identifier and a registered interrupt output.

Top module: `uart_regbank`

## Requirements
- R1: When line control bit 7 is 1, offset 0 reads and writes divisor bits 7..0 and offset 1 reads and writes divisor bits 15..8. When that bit is 0, writes to offsets 0 and 1 leave the divisor unchanged.
- R2: When line control bit 7 is 0, a write to offset 0 puts the byte on `tx_data` and pulses `tx_load` for one clock. A read of offset 0 returns `rx_data` and pulses `rx_take` for one clock.
- R3: The line control byte drives the format outputs. Bits 1..0 give `word_len` (0 to 3 mean 5 to 8 bits), bit 2 gives `two_stop`, bit 3 gives `parity_en`, bit 4 gives `even_parity`, bit 5 gives `stick_parity` and bit 6 gives `send_break`. A read of offset 3 returns the whole byte.
- R4: Reserved bits read as zero. These are modem control (offset 4) bits 7..5, interrupt enable (offset 1, bit 7 of line control clear) bits 7..4, interrupt ID (offset 2) bits 7..3 and line status (offset 5) bit 7. Writes to offsets 2, 5, 6 and 7 are ignored, and offset 7 reads as zero.
- R5: Offset 5 reads {0, tsr_empty, thr_empty, rx_break, rx_frame_err, rx_parity_err, rx_overrun, rx_ready} from bit 7 down, and the read pulses `lsr_take` for one clock.
- R6: Offset 6 bits 7..4 hold DCD, RI, DSR and CTS. Outside loop mode these come from the pins through a two-stage synchroniser, so a pin change is visible three clocks later.
- R7: Modem control bits 0..3 drive `dtr_out`, `rts_out`, `out1_out` and `out2_out`. When bit 4 is set, DTR is seen as CTS, RTS as DSR, OUT1 as DCD and OUT2 as RI, one clock after the write. The pins are ignored in this mode.
- R8: Offset 6 bits 3, 1 and 0 set on any change of DCD, DSR and CTS. Bit 2 sets only when RI goes from 1 to 0. A read of offset 6 clears all four bits, but a change in the same clock still sets its bit.
- R9: Offset 2 bit 0 is 0 when an interrupt is pending, and bits 2..1 give the highest enabled source. The codes are line error (enable bit 2) 11, data ready (enable bit 0) 10, transmitter empty (enable bit 1) 01 and modem change (enable bit 3) 00. With nothing pending the byte reads 0x01.
- R10: The transmitter-empty source sets on a 0-to-1 change of `thr_empty`, or on the first clock after reset when `thr_empty` is 1. It clears on a transmit write, or on a read of offset 2 that returns code 01. A set in the same clock wins over a clear.
- R11: `irq` equals the pending state of the previous clock, so it is the inverse of bit 0 of any interrupt ID read returned at the same time.
- R12: After synchronous reset, line control, modem control and interrupt enable are 0, the divisor is 12 (9600 baud), the modem flags are 0 and all strobes and `irq` are 0.
- R13: `rdata` changes only on the clock after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Received byte from shift engine |
| rx_ready | input | 1 | Received byte available |
| rx_overrun | input | 1 | Overrun error flag |
| rx_parity_err | input | 1 | Parity error flag |
| rx_frame_err | input | 1 | Framing error flag |
| rx_break | input | 1 | Break detected flag |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shifter empty |
| tx_data | output | 8 | Byte to transmit |
| tx_load | output | 1 | One-clock pulse: new transmit byte |
| rx_take | output | 1 | One-clock pulse: receive buffer read |
| lsr_take | output | 1 | One-clock pulse: line status read |
| word_len | output | 2 | Data bits minus 5 |
| two_stop | output | 1 | More than one stop bit |
| parity_en | output | 1 | Parity enabled |
| even_parity | output | 1 | Even parity |
| stick_parity | output | 1 | Stick parity |
| send_break | output | 1 | Force break on line |
| divisor | output | 16 | Baud divisor |
| cts_in | input | 1 | Clear-to-send pin |
| dsr_in | input | 1 | Data-set-ready pin |
| ri_in | input | 1 | Ring pin |
| dcd_in | input | 1 | Carrier-detect pin |
| dtr_out | output | 1 | Terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences start each from a fresh reset. The divisor is written with the alias bit set and cleared, which separates divisor access from data and enable access on the shared offsets. Loop mode is driven with single modem control bits and then with bits cleared, which shows the cross-wiring and separates a rising RI edge from a falling one. Line error, data-ready, transmitter-empty and modem-change conditions are removed one at a time, so the interrupt identifier walks down its priority order. A long phase of random offsets, strobes, pin levels and engine flags is compared on every clock against a behavioural model. This catches wrong clear-versus-set ordering and wrong synchroniser latency.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  typedef enum logic [2:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCR   = 3'd3,
    OFS_MCR   = 3'd4,
    OFS_LSR   = 3'd5,
    OFS_MSR   = 3'd6,
    OFS_SPARE = 3'd7
  } reg_ofs_e;

  // interrupt identification codes, value order follows priority
  typedef enum logic [1:0] {
    SRC_MODEM  = 2'b00,
    SRC_THRE   = 2'b01,
    SRC_RXDATA = 2'b10,
    SRC_LINE   = 2'b11
  } irq_src_e;

  typedef struct packed {
    logic       dlab;
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop2;
    logic [1:0] wlen;
  } lcr_t;

  localparam int MODEM_LINES = 4;
  localparam int MCR_BITS    = 5;
  localparam int IEN_BITS    = 4;

  // modem nibble order {dcd, ri, dsr, cts}; control order {loop, out2, out1, rts, dtr}
  function automatic logic [MODEM_LINES-1:0] loop_map(input logic [MCR_BITS-1:0] mcr);
    return {mcr[2], mcr[3], mcr[1], mcr[0]};
  endfunction

endpackage

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import uart_regbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MODEM_LINES-1:0] pins,
  input  logic                   loop_en,
  input  logic [MODEM_LINES-1:0] loop_src,
  input  logic                   clr_delta,
  output logic [2*MODEM_LINES-1:0] msr
);

  logic [SYNC_STAGES-1:0][MODEM_LINES-1:0] sync_q;
  logic [MODEM_LINES-1:0] src, cur_q, delta_q, delta_set;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pins;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pins};
      end
    end
  endgenerate

  assign src = loop_en ? loop_src : sync_q[SYNC_STAGES-1];

  // bit 2 is ring: trailing edge only; the others flag any change
  assign delta_set = {cur_q[3] ^ src[3],
                      cur_q[2] & ~src[2],
                      cur_q[1] ^ src[1],
                      cur_q[0] ^ src[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      delta_q <= '0;
    end else begin
      cur_q   <= src;
      delta_q <= (clr_delta ? '0 : delta_q) | delta_set;
    end
  end

  assign msr = {cur_q, delta_q};

endmodule

// File: rtl/uart_thre_src.sv
module uart_thre_src (
  input  logic clk,
  input  logic rst,
  input  logic thr_empty,
  input  logic thr_write,
  input  logic iid_ack,
  output logic pend
);

  logic prev_q, pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= thr_empty;
      if (thr_empty && !prev_q)      pend_q <= 1'b1;
      else if (thr_write || iid_ack) pend_q <= 1'b0;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regbank_pkg::*;
(
  input  logic [IEN_BITS-1:0] ien,
  input  logic                rx_cond,
  input  logic                tx_cond,
  input  logic                line_cond,
  input  logic                ms_cond,
  output irq_src_e            iid,
  output logic                pending
);

  logic [IEN_BITS-1:0] act;
  assign act = ien & {ms_cond, line_cond, tx_cond, rx_cond};

  always_comb begin
    pending = |act;
    if (act[2])      iid = SRC_LINE;
    else if (act[0]) iid = SRC_RXDATA;
    else if (act[1]) iid = SRC_THRE;
    else             iid = SRC_MODEM;
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_RESET   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [DATA_W-1:0]   rx_data,
  input  logic                rx_ready,
  input  logic                rx_overrun,
  input  logic                rx_parity_err,
  input  logic                rx_frame_err,
  input  logic                rx_break,
  input  logic                thr_empty,
  input  logic                tsr_empty,
  output logic [DATA_W-1:0]   tx_data,
  output logic                tx_load,
  output logic                rx_take,
  output logic                lsr_take,
  output logic [1:0]          word_len,
  output logic                two_stop,
  output logic                parity_en,
  output logic                even_parity,
  output logic                stick_parity,
  output logic                send_break,
  output logic [2*DATA_W-1:0] divisor,
  input  logic                cts_in,
  input  logic                dsr_in,
  input  logic                ri_in,
  input  logic                dcd_in,
  output logic                dtr_out,
  output logic                rts_out,
  output logic                out1_out,
  output logic                out2_out,
  output logic                irq
);

  localparam int DIV_W = 2 * DATA_W;

  lcr_t                lcr_q;
  logic [MCR_BITS-1:0] mcr_q;
  logic [IEN_BITS-1:0] ien_q;
  logic [DIV_W-1:0]    div_q;
  logic [DATA_W-1:0]   rdata_q, tx_data_q;
  logic                tx_load_q, rx_take_q, lsr_take_q, irq_q;

  logic dlab;
  logic wr_thr, wr_dll, wr_dlm, wr_ien, wr_lcr, wr_mcr;
  logic rd_rbr, rd_iid, rd_lsr, rd_msr;
  logic [2*MODEM_LINES-1:0] msr_w;
  logic     thre_pend, pending, iid_ack, line_cond;
  irq_src_e iid;
  logic [7:0]        lsr_val;
  logic [DATA_W-1:0] rd_val;

  assign dlab   = lcr_q.dlab;
  assign wr_thr = wr_en && addr == OFS_DATA && !dlab;
  assign wr_dll = wr_en && addr == OFS_DATA &&  dlab;
  assign wr_ien = wr_en && addr == OFS_IEN  && !dlab;
  assign wr_dlm = wr_en && addr == OFS_IEN  &&  dlab;
  assign wr_lcr = wr_en && addr == OFS_LCR;
  assign wr_mcr = wr_en && addr == OFS_MCR;
  assign rd_rbr = rd_en && addr == OFS_DATA && !dlab;
  assign rd_iid = rd_en && addr == OFS_IID;
  assign rd_lsr = rd_en && addr == OFS_LSR;
  assign rd_msr = rd_en && addr == OFS_MSR;

  uart_modem_status #(.SYNC_STAGES(SYNC_STAGES)) u_modem (
    .clk       (clk),
    .rst       (rst),
    .pins      ({dcd_in, ri_in, dsr_in, cts_in}),
    .loop_en   (mcr_q[4]),
    .loop_src  (loop_map(mcr_q)),
    .clr_delta (rd_msr),
    .msr       (msr_w)
  );

  uart_thre_src u_thre (
    .clk       (clk),
    .rst       (rst),
    .thr_empty (thr_empty),
    .thr_write (wr_thr),
    .iid_ack   (iid_ack),
    .pend      (thre_pend)
  );

  assign line_cond = rx_overrun | rx_parity_err | rx_frame_err | rx_break;

  uart_irq_prio u_prio (
    .ien       (ien_q),
    .rx_cond   (rx_ready),
    .tx_cond   (thre_pend),
    .line_cond (line_cond),
    .ms_cond   (|msr_w[MODEM_LINES-1:0]),
    .iid       (iid),
    .pending   (pending)
  );

  assign iid_ack = rd_iid && pending && iid == SRC_THRE;
  assign lsr_val = {1'b0, tsr_empty, thr_empty, rx_break, rx_frame_err,
                    rx_parity_err, rx_overrun, rx_ready};

  always_comb begin
    rd_val = '0;
    case (addr)
      OFS_DATA: rd_val = dlab ? div_q[DATA_W-1:0] : rx_data;
      OFS_IEN:  if (dlab) rd_val = div_q[DIV_W-1:DATA_W];
                else      rd_val[IEN_BITS-1:0] = ien_q;
      OFS_IID:  rd_val[2:0] = {iid, ~pending};
      OFS_LCR:  rd_val[7:0] = lcr_q;
      OFS_MCR:  rd_val[MCR_BITS-1:0] = mcr_q;
      OFS_LSR:  rd_val[7:0] = lsr_val;
      OFS_MSR:  rd_val[7:0] = msr_w;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q      <= '0;
      mcr_q      <= '0;
      ien_q      <= '0;
      div_q      <= DIV_W'(DIV_RESET);
      rdata_q    <= '0;
      tx_data_q  <= '0;
      tx_load_q  <= 1'b0;
      rx_take_q  <= 1'b0;
      lsr_take_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_lcr) lcr_q <= wdata[7:0];
      if (wr_mcr) mcr_q <= wdata[MCR_BITS-1:0];
      if (wr_ien) ien_q <= wdata[IEN_BITS-1:0];
      if (wr_dll) div_q[DATA_W-1:0]     <= wdata;
      if (wr_dlm) div_q[DIV_W-1:DATA_W] <= wdata;
      if (wr_thr) tx_data_q <= wdata;
      if (rd_en)  rdata_q   <= rd_val;
      tx_load_q  <= wr_thr;
      rx_take_q  <= rd_rbr;
      lsr_take_q <= rd_lsr;
      irq_q      <= pending;
    end
  end

  assign rdata        = rdata_q;
  assign tx_data      = tx_data_q;
  assign tx_load      = tx_load_q;
  assign rx_take      = rx_take_q;
  assign lsr_take     = lsr_take_q;
  assign irq          = irq_q;
  assign divisor      = div_q;
  assign word_len     = lcr_q.wlen;
  assign two_stop     = lcr_q.stop2;
  assign parity_en    = lcr_q.par_en;
  assign even_parity  = lcr_q.even;
  assign stick_parity = lcr_q.stick;
  assign send_break   = lcr_q.brk;
  assign dtr_out      = mcr_q[0];
  assign rts_out      = mcr_q[1];
  assign out1_out     = mcr_q[2];
  assign out2_out     = mcr_q[3];

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic [DATA_W-1:0]   tx_data,
  input logic                tx_load,
  input logic [2*DATA_W-1:0] divisor,
  input logic                irq,
  input logic                dlab,
  input logic [7:0]          msr
);

  // R1
  div_hi_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == 3'd1 && dlab |=> divisor[2*DATA_W-1:DATA_W] == $past(wdata));

  // R2
  tx_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == 3'd0 && !dlab |=> tx_load && tx_data == $past(wdata));

  // R4
  mcr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == 3'd4 |=> rdata[7:5] == 3'b000);

  // R9
  iid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == 3'd2 |=> rdata[7:3] == 5'b00000);

  // R11
  irq_iid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == 3'd2 |=> rdata[0] == !irq);

  // R8
  ri_trail_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(msr[6]) |-> msr[2]);

endmodule

bind uart_regbank uart_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .wdata   (wdata),
  .rdata   (rdata),
  .tx_data (tx_data),
  .tx_load (tx_load),
  .divisor (divisor),
  .irq     (irq),
  .dlab    (dlab),
  .msr     (msr_w)
);

// File: tb/uart_regbank_bench.sv
`timescale 1ns/1ps
module uart_regbank_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic rx_ready = 0, rx_overrun = 0, rx_parity_err = 0, rx_frame_err = 0, rx_break = 0;
  logic thr_empty = 1, tsr_empty = 1;
  logic cts_in = 0, dsr_in = 0, ri_in = 0, dcd_in = 0;
  logic [7:0] rdata, tx_data;
  logic tx_load, rx_take, lsr_take, two_stop, parity_en, even_parity, stick_parity, send_break;
  logic [1:0] word_len;
  logic [15:0] divisor;
  logic dtr_out, rts_out, out1_out, out2_out, irq;

  uart_regbank u_uart_regbank (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .rx_break(rx_break),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .tx_data(tx_data), .tx_load(tx_load),
    .rx_take(rx_take), .lsr_take(lsr_take), .word_len(word_len), .two_stop(two_stop),
    .parity_en(parity_en), .even_parity(even_parity), .stick_parity(stick_parity),
    .send_break(send_break), .divisor(divisor), .cts_in(cts_in), .dsr_in(dsr_in),
    .ri_in(ri_in), .dcd_in(dcd_in), .dtr_out(dtr_out), .rts_out(rts_out),
    .out1_out(out1_out), .out2_out(out2_out), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit armed = 0, done = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  logic [7:0] m_lcr = 0, m_rdata = 0, m_txd = 0, rv;
  logic [4:0] m_mcr = 0;
  logic [3:0] m_ier = 0, m_s1 = 0, m_s2 = 0, m_cur = 0, m_dl = 0, src, setv;
  logic [15:0] m_div = 16'd12;
  logic m_tp = 0, m_prev = 0, m_txl = 0, m_rbr = 0, m_lsrr = 0, m_irq = 0;
  logic pend, odlab, clr;
  logic [1:0] code;

  always @(posedge clk) begin
    if (rst) begin
      m_lcr = 0; m_mcr = 0; m_ier = 0; m_div = 16'd12; m_rdata = 0; m_txd = 0;
      m_s1 = 0; m_s2 = 0; m_cur = 0; m_dl = 0; m_tp = 0; m_prev = 0;
      m_txl = 0; m_rbr = 0; m_lsrr = 0; m_irq = 0;
      armed = 1;
    end else begin
      odlab = m_lcr[7];
      pend = 1; code = 2'b00;
      if (m_ier[2] && (rx_overrun || rx_parity_err || rx_frame_err || rx_break)) code = 2'b11;
      else if (m_ier[0] && rx_ready) code = 2'b10;
      else if (m_ier[1] && m_tp) code = 2'b01;
      else if (m_ier[3] && m_dl != 0) code = 2'b00;
      else pend = 0;
      case (addr)
        3'd0: rv = odlab ? m_div[7:0] : rx_data;
        3'd1: rv = odlab ? m_div[15:8] : {4'b0, m_ier};
        3'd2: rv = {5'b0, code, !pend};
        3'd3: rv = m_lcr;
        3'd4: rv = {3'b0, m_mcr};
        3'd5: rv = {1'b0, tsr_empty, thr_empty, rx_break, rx_frame_err, rx_parity_err, rx_overrun, rx_ready};
        3'd6: rv = {m_cur, m_dl};
        default: rv = 8'h00;
      endcase
      src  = m_mcr[4] ? {m_mcr[2], m_mcr[3], m_mcr[1], m_mcr[0]} : m_s2;
      setv = {m_cur[3] != src[3], m_cur[2] && !src[2], m_cur[1] != src[1], m_cur[0] != src[0]};
      m_dl = ((rd_en && addr == 3'd6) ? 4'b0 : m_dl) | setv;
      clr  = (wr_en && addr == 3'd0 && !odlab) || (rd_en && addr == 3'd2 && pend && code == 2'b01);
      if (thr_empty && !m_prev) m_tp = 1; else if (clr) m_tp = 0;
      m_prev = thr_empty;
      m_cur = src; m_s2 = m_s1; m_s1 = {dcd_in, ri_in, dsr_in, cts_in};
      if (rd_en) m_rdata = rv;
      m_txl  = wr_en && addr == 3'd0 && !odlab;
      m_rbr  = rd_en && addr == 3'd0 && !odlab;
      m_lsrr = rd_en && addr == 3'd5;
      m_irq  = pend;
      if (m_txl) m_txd = wdata;
      if (wr_en && addr == 3'd3) m_lcr = wdata;
      if (wr_en && addr == 3'd4) m_mcr = wdata[4:0];
      if (wr_en && addr == 3'd1 && !odlab) m_ier = wdata[3:0];
      if (wr_en && addr == 3'd0 && odlab) m_div[7:0] = wdata;
      if (wr_en && addr == 3'd1 && odlab) m_div[15:8] = wdata;
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R13 rdata", rdata, m_rdata);
      chk("R2 tx_data", tx_data, m_txd);
      chk("R2 strobes", {tx_load, rx_take}, {m_txl, m_rbr});
      chk("R5 lsr_take", lsr_take, m_lsrr);
      chk("R1 divisor", divisor, m_div);
      chk("R3 format", {send_break, stick_parity, even_parity, parity_en, two_stop, word_len}, m_lcr[6:0]);
      chk("R7 modem outs", {out2_out, out1_out, rts_out, dtr_out}, m_mcr[3:0]);
      chk("R11 irq", irq, m_irq);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1; tick(3); rst = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd_en = 1; tick(); rd_en = 0;
    chk(tag, rdata, exp);
  endtask

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 divisor reset", divisor, 16'd12);
    chk("R12 irq reset", irq, 1'b0);
    rd_expect(3'd3, 8'h00, "R12 lcr reset");
    rd_expect(3'd2, 8'h01, "R12 no pending");

    // R1 divisor aliasing, 75 baud
    wr(3'd3, 8'h83); wr(3'd0, 8'h00); wr(3'd1, 8'h06);
    chk("R1 divisor 1536", divisor, 16'd1536);
    rd_expect(3'd1, 8'h06, "R1 read high byte");
    rd_expect(3'd0, 8'h00, "R1 read low byte");
    // R2 data path with alias clear
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h5A);
    chk("R2 tx byte", tx_data, 8'h5A);
    rx_data = 8'hC3;
    rd_expect(3'd0, 8'hC3, "R2 rx byte");
    wr(3'd1, 8'h05);
    chk("R1 divisor untouched", divisor, 16'd1536);

    // R3 format decode
    do_reset();
    wr(3'd3, 8'h7E);
    chk("R3 fields", {send_break, stick_parity, even_parity, parity_en, two_stop, word_len}, 7'h7E);
    rd_expect(3'd3, 8'h7E, "R3 readback");

    // R4 reserved bits and ignored offsets
    do_reset();
    wr(3'd1, 8'hFF);
    rd_expect(3'd1, 8'h0F, "R4 ier reserved");
    wr(3'd7, 8'hAA);
    rd_expect(3'd7, 8'h00, "R4 spare offset");
    wr(3'd4, 8'hFF);
    rd_expect(3'd4, 8'h1F, "R4 mcr reserved");

    // R5 line status composition
    do_reset();
    rx_break = 1; rx_parity_err = 1; rx_ready = 1; tsr_empty = 0;
    rd_expect(3'd5, 8'h35, "R5 lsr layout");
    chk("R5 lsr_take pulse", lsr_take, 1'b1);
    rx_break = 0; rx_parity_err = 0; rx_ready = 0; tsr_empty = 1;

    // R6 pin path latency
    do_reset();
    cts_in = 1; tick(3);
    rd_expect(3'd6, 8'h11, "R6 cts after sync");
    cts_in = 0;
    tick(4);

    // R7 loop cross-wiring
    do_reset();
    wr(3'd4, 8'h15); tick();
    rd_expect(3'd6, 8'h99, "R7 dtr->cts out1->dcd");
    // R8 cleared by read
    rd_expect(3'd6, 8'h90, "R8 deltas cleared");
    ri_in = 1; tick(4);
    rd_expect(3'd6, 8'h90, "R7 pins ignored in loop");
    ri_in = 0; tick(3);
    chk("R13 rdata holds", rdata, 8'h90);

    // R8 trailing-edge ring
    do_reset();
    wr(3'd4, 8'h18); tick();
    rd_expect(3'd6, 8'h40, "R8 ri rise no flag");
    wr(3'd4, 8'h10); tick();
    rd_expect(3'd6, 8'h04, "R8 ri fall flag");
    rd_expect(3'd6, 8'h00, "R8 cleared");

    // R9 priority walk, R10 and R11
    do_reset();
    wr(3'd1, 8'h0F);
    rx_ready = 1; rx_overrun = 1;
    rd_expect(3'd2, 8'h06, "R9 line highest");
    rx_overrun = 0;
    rd_expect(3'd2, 8'h04, "R9 rx data");
    rx_ready = 0;
    rd_expect(3'd2, 8'h02, "R9 thre");
    rd_expect(3'd2, 8'h01, "R10 cleared by id read");
    cts_in = 1; tick(4);
    chk("R11 irq on modem change", irq, 1'b1);
    rd_expect(3'd2, 8'h00, "R9 modem lowest");
    rd_expect(3'd6, 8'h11, "R8 cts delta");
    tick(1);
    chk("R11 irq drops", irq, 1'b0);
    cts_in = 0; tick(4);

    // R10 transmit write clears, rising empty sets
    do_reset();
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h33);
    rd_expect(3'd2, 8'h01, "R10 cleared by write");
    thr_empty = 0; tick();
    thr_empty = 1; tick();
    rd_expect(3'd2, 8'h02, "R10 set on rising empty");

    // random phase against the model
    for (int i = 0; i < 1500; i++) begin
      addr = 3'($urandom % 8);
      wdata = 8'($urandom);
      wr_en = ($urandom % 3) == 0;
      rd_en = ($urandom % 3) == 0;
      rx_data = 8'($urandom);
      {rx_ready, rx_overrun, rx_parity_err, rx_frame_err, rx_break} = 5'($urandom) & 5'($urandom);
      if (($urandom % 4) == 0) thr_empty = ~thr_empty;
      tsr_empty = 1'($urandom);
      if (($urandom % 6) == 0) {dcd_in, ri_in, dsr_in, cts_in} = 4'($urandom);
      if (i % 500 == 499) begin wr_en = 0; rd_en = 0; do_reset(); end
      else tick();
    end
    wr_en = 0; rd_en = 0; tick(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule